// File: doc/BRIEF.md
# Serial Column and Row Driver for a Two-Colour Dot Matrix Tile

This block is the logic side of one tile in a chain of two-colour LED matrix tiles. Red and green pixel data arrive as two serial streams. Each stream is clocked into its own 32-stage shift register. A load control makes a column hold stage either follow the shift registers or freeze them, so a new row can be shifted in while the previous row stays on display.

A 4-bit row address is decoded to a single active row line. A blanking input turns off every row and every column at once. Only set dots light: a 1 in the data means on, a 0 means off. The address, load, blank and clock inputs are passed to the next tile in the chain. The far end of each shift register is also passed on, so tiles can be cascaded with no glue logic between them.

Top module: `dot_tile_drv`

## Requirements
- R1: On each rising edge of `clk_i`, both colour registers move one place toward bit 31 and take their serial input into bit 0. A bit shifted in appears at bit 31 after 32 edges.
- R2: While `load_i` is 1 and `blank_i` is 0, `red_col_o` and `grn_col_o` equal the current register contents.
- R3: While `load_i` is 0, the column outputs keep the register contents from the last edge at which `load_i` was 1, whatever is shifted in meanwhile (ignoring blanking).
- R4: While `blank_i` is 0, `row_sel_o` is one-hot, and bit n is set where n is the unsigned value of `addr_i`.
- R5: While `blank_i` is 1, `row_sel_o` and both column outputs are all zero.
- R6: A column output bit of 1 drives a lit dot. A data bit shifted in as 1 shows as 1 at its column position.
- R7: `red_ser_o` and `grn_ser_o` equal bit 31 of their register, which is the bit that leaves the register at the next edge.
- R8: `addr_o`, `load_o`, `blank_o` and `clk_o` are direct copies of `addr_i`, `load_i`, `blank_i` and `clk_i`.
- R9: While `rst_ni` is 0, both registers and both column hold stages are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Row address |
| red_ser_i | input | 1 | Red serial data |
| grn_ser_i | input | 1 | Green serial data |
| load_i | input | 1 | 1: columns follow the registers; 0: columns hold |
| blank_i | input | 1 | 1: all rows and columns off |
| red_col_o | output | 32 | Red column drive |
| grn_col_o | output | 32 | Green column drive |
| row_sel_o | output | 16 | Row select |
| addr_o | output | 4 | Address to the next tile |
| red_ser_o | output | 1 | Red register tail to the next tile |
| grn_ser_o | output | 1 | Green register tail to the next tile |
| load_o | output | 1 | Load to the next tile |
| blank_o | output | 1 | Blank to the next tile |
| clk_o | output | 1 | Clock to the next tile |

## Verification
The assertions check the following on every clock:
- the one-place advance of each register and the tail bit,
- the one-hot row select for the current address,
- the all-off state under blanking,
- the stability of the columns across cycles with load low.

Some behaviour shows only in the bench scenarios:
- a single marked bit arriving at bit 31 after exactly 32 edges;
- the frozen columns being released by a later load pulse;
- a sweep over all sixteen addresses;
- blanking arriving in the middle of shifting.

A behavioural model built from bit queues compares every output on every clock.

// File: rtl/dot_tile_pkg.sv
package dot_tile_pkg;
  localparam int unsigned COL_W  = 32;
  localparam int unsigned ROW_N  = 16;
  localparam int unsigned ADDR_W = $clog2(ROW_N);
  localparam int unsigned CLR_N  = 2;   // 0: red, 1: green
endpackage

// File: rtl/serial_shift.sv
module serial_shift #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] nxt_o,
  output logic         tail_o
);
  logic [W-1:0] sr_q;

  assign nxt_o  = {sr_q[W-2:0], ser_i};
  assign cur_o  = sr_q;
  assign tail_o = sr_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= nxt_o;
  end

  p_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_o[W-1:1] == $past(cur_o[W-2:0]));
  p_tail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_o == $past(cur_o[W-2]));
endmodule

// File: rtl/col_hold.sv
module col_hold #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] nxt_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;

  // Clocked stand-in for a transparent latch: hold tracks what the register becomes.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (load_i) hold_q <= nxt_i;
  end

  assign q_o = load_i ? cur_i : hold_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && $past(!load_i)) |-> $stable(q_o));
endmodule

// File: rtl/row_decode.sv
module row_decode #(
  parameter int unsigned N = 16,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic [AW-1:0] addr_i,
  input  logic          en_i,
  output logic [N-1:0]  row_o
);
  for (genvar r = 0; r < N; r++) begin : g_row
    assign row_o[r] = en_i && (addr_i == AW'(r));
  end
endmodule

// File: rtl/dot_tile_drv.sv
module dot_tile_drv
  import dot_tile_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              red_ser_i,
  input  logic              grn_ser_i,
  input  logic              load_i,
  input  logic              blank_i,
  output logic [COL_W-1:0]  red_col_o,
  output logic [COL_W-1:0]  grn_col_o,
  output logic [ROW_N-1:0]  row_sel_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              red_ser_o,
  output logic              grn_ser_o,
  output logic              load_o,
  output logic              blank_o,
  output logic              clk_o
);
  logic [CLR_N-1:0]            ser_in, ser_tail;
  logic [CLR_N-1:0][COL_W-1:0] cur, nxt, col;

  assign ser_in = {grn_ser_i, red_ser_i};

  for (genvar c = 0; c < CLR_N; c++) begin : g_clr
    serial_shift #(.W(COL_W)) u_shift (
      .clk_i (clk_i), .rst_ni (rst_ni), .ser_i (ser_in[c]),
      .cur_o (cur[c]), .nxt_o (nxt[c]), .tail_o (ser_tail[c])
    );
    col_hold #(.W(COL_W)) u_hold (
      .clk_i (clk_i), .rst_ni (rst_ni), .load_i (load_i),
      .cur_i (cur[c]), .nxt_i (nxt[c]), .q_o (col[c])
    );
  end

  row_decode #(.N(ROW_N)) u_rows (
    .addr_i (addr_i), .en_i (!blank_i), .row_o (row_sel_o)
  );

  assign red_col_o = blank_i ? '0 : col[0];
  assign grn_col_o = blank_i ? '0 : col[1];
  assign red_ser_o = ser_tail[0];
  assign grn_ser_o = ser_tail[1];
  assign addr_o    = addr_i;
  assign load_o    = load_i;
  assign blank_o   = blank_i;
  assign clk_o     = clk_i;

  p_row_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_i |-> ($countones(row_sel_o) == 1 && row_sel_o[addr_i]));
  p_blank_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> (row_sel_o == '0 && red_col_o == '0 && grn_col_o == '0));
  p_row_onehot0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_sel_o));
endmodule

// File: tb/dot_tile_drv_tb.sv
module dot_tile_drv_tb;
  logic        clk_i = 0, rst_ni = 0;
  logic [3:0]  addr_i = 0;
  logic        red_ser_i = 0, grn_ser_i = 0, load_i = 0, blank_i = 0;
  logic [31:0] red_col_o, grn_col_o;
  logic [15:0] row_sel_o;
  logic [3:0]  addr_o;
  logic        red_ser_o, grn_ser_o, load_o, blank_o, clk_o;

  dot_tile_drv u_dut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit rq[$], gq[$];          // newest bit at index 0
  logic [31:0] r_held, g_held;

  function automatic logic [31:0] vec(bit q[$]);
    logic [31:0] v = '0;
    for (int k = 0; k < 32; k++) v[k] = q[k];
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [31:0] er, eg;
    logic [15:0] erow;
    er   = blank_i ? '0 : (load_i ? vec(rq) : r_held);
    eg   = blank_i ? '0 : (load_i ? vec(gq) : g_held);
    erow = blank_i ? '0 : (16'h1 << addr_i);
    chk("R2/R3/R5/R6 red cols", red_col_o, er);
    chk("R2/R3/R5/R6 grn cols", grn_col_o, eg);
    chk("R4/R5 rows", {16'h0, row_sel_o}, {16'h0, erow});
    chk("R7 red tail", {31'h0, red_ser_o}, {31'h0, rq[31]});
    chk("R7 grn tail", {31'h0, grn_ser_o}, {31'h0, gq[31]});
    chk("R8 passthru", {24'h0, addr_o, load_o, blank_o, clk_o},
        {24'h0, addr_i, load_i, blank_i, clk_i});
  endtask

  // drive at negedge, model the edge, compare 1 ns after it
  task automatic cyc(bit r, bit g, bit ld, bit bl, logic [3:0] a);
    @(negedge clk_i);
    red_ser_i = r; grn_ser_i = g; load_i = ld; blank_i = bl; addr_i = a;
    @(posedge clk_i);
    rq.push_front(r); void'(rq.pop_back());
    gq.push_front(g); void'(gq.pop_back());
    if (ld) begin r_held = vec(rq); g_held = vec(gq); end
    #1 compare_all();
  endtask

  initial begin
    logic [31:0] frozen;
    for (int k = 0; k < 32; k++) begin rq.push_back(0); gq.push_back(0); end
    r_held = '0; g_held = '0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R9 reset red", red_col_o, 32'h0);
    chk("R9 reset grn", grn_col_o, 32'h0);
    chk("R9 reset tail", {31'h0, red_ser_o | grn_ser_o}, 32'h0);
    load_i = 1; #1;
    chk("R9 reset regs via load", red_col_o | grn_col_o, 32'h0);
    load_i = 0;
    @(negedge clk_i) rst_ni = 1;

    // R1: single marked bit travels to bit 31 in 32 edges
    for (int k = 0; k < 32; k++) cyc(k == 0, k[0], 1, 0, 4'd5);
    chk("R1 marked bit at 31", red_col_o, 32'h8000_0000);
    chk("R6 lit pattern grn", grn_col_o, 32'h5555_5555);
    chk("R7 tail is first bit", {31'h0, red_ser_o}, 32'h1);

    // R3: freeze while shifting new data
    frozen = red_col_o;
    for (int k = 0; k < 20; k++) cyc(1, ~k[1], 0, 0, 4'd9);
    chk("R3 red frozen", red_col_o, frozen);
    cyc(0, 0, 1, 0, 4'd9);   // release: R2

    // R4: address sweep
    for (int a = 0; a < 16; a++) begin
      cyc(a[0], a[2], 1, 0, 4'(a));
      chk("R4 row select", {16'h0, row_sel_o}, {16'h0, 16'h1 << a});
    end

    // R5: blank in the middle of shifting, then unblank
    for (int k = 0; k < 8; k++) cyc(1, 1, 1, 1, 4'(k));
    chk("R5 blank rows", {16'h0, row_sel_o}, 32'h0);
    cyc(0, 1, 0, 0, 4'd3);

    // mixed random traffic
    for (int k = 0; k < 400; k++)
      cyc($urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1,
          $urandom_range(9, 0) < 3, $urandom_range(19, 0) < 3,
          4'($urandom_range(15, 0)));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule